// File: doc/BRIEF.md
# T1 Transmit Channel Overwrite Unit

This block sits in the transmit path of a T1 framer and edits the 24 channel bytes of each 193-bit frame before they reach the line. The stream arrives one slot per valid cycle. A slot flagged as the framing slot carries the framing bit and starts a frame. The next 24 slots are channels 1 to 24 in order. Every slot leaves the block one clock later.

For each channel, the unit checks per-channel masks. An idle channel has its whole byte replaced by a programmable idle code. A clear channel passes untouched. Any other channel gets two edits. In signaling frames, its least significant bit (T1 bit 8) is robbed for that channel's signaling bit. Then, if the byte is all zeros, bit 7 is forced high so the line never carries an all-zero octet.

All configuration is captured at the framing slot, so a frame is always edited with one consistent set of settings. The channel sequencer is a three-state machine:
- `SL_HUNT`: after reset, before the first framing slot.
- `SL_CHAN`: counting channels 1 to 24.
- `SL_GAP`: after channel 24, until the next framing slot.

Transitions:
- `HUNT->CHAN`, `CHAN->CHAN` and `GAP->CHAN` happen on any framing slot.
- `CHAN->GAP` happens on the 24th channel slot.

Top module: `t1_tx_overwrite`

## Requirements
- R1: A valid slot with `in_fbit`=1 leaves one cycle later with `out_fbit`=1 and all eight data bits unchanged.
- R2: The k-th valid non-framing slot after a framing slot is channel k (k = 1..24). Channel k is controlled by bit k-1 of `clear_mask`, `idle_mask` and `sig_bits`.
- R3: A channel whose idle bit is 1 is output as the idle code, whatever its data and whatever its clear bit.
- R4: In a frame whose framing slot had `sig_frame`=1, a channel that is neither idle nor clear has its LSB (`out_data[0]`, T1 bit 8) set to its signaling bit. When `sig_frame`=0, the LSB passes through.
- R5: For a channel that is neither idle nor clear, a byte that is 0x00 after robbing is output as 0x02 (bit index 1, T1 bit 7, set).
- R6: A clear channel that is not idle is output unchanged, including 0x00 and including in signaling frames.
- R7: The masks, idle code, signaling bits and `sig_frame` are captured only at a framing slot. Changes between framing slots have no effect until the next frame.
- R8: Non-framing slots before the first framing slot, and after channel 24 until the next framing slot, are output unchanged.
- R9: `out_valid` is `in_valid` delayed by one cycle.
- R10: After reset, `out_valid`, `out_fbit` and `out_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A slot is present this cycle |
| in_fbit | input | 1 | The present slot is the framing slot |
| in_data | input | 8 | Slot data (MSB = T1 bit 1) |
| sig_frame | input | 1 | Frame being started is a signaling frame (sampled at framing slot) |
| sig_bits | input | 24 | Signaling bit per channel, bit k-1 = channel k |
| clear_mask | input | 24 | Clear-channel selection, bit k-1 = channel k |
| idle_mask | input | 24 | Idle-channel selection, bit k-1 = channel k |
| idle_code | input | 8 | Replacement byte for idle channels |
| out_valid | output | 1 | Output slot present |
| out_fbit | output | 1 | Output slot is the framing slot |
| out_data | output | 8 | Edited slot data |

## Verification
Every result is due exactly one rising edge after the slot that causes it. This applies to framing slots, edited channels and the valid flag alike. Settings captured at a framing slot first apply to channel 1, which arrives one slot later.

The bench drives each slot at a falling edge and waits for the next rising edge. It then reads the outputs 1 ns later, so every check sees the register loaded by that slot.

For R7, settings are changed only after a channel slot's check. The bench then observes the following channel slots of the same frame, and then channel 1 of the next frame.

// File: rtl/t1ow_pkg.sv
package t1ow_pkg;

    typedef enum logic [1:0] {
        SL_HUNT = 2'd0,
        SL_CHAN = 2'd1,
        SL_GAP  = 2'd2
    } slot_state_e;

endpackage

// File: rtl/t1ow_cfg_shadow.sv
module t1ow_cfg_shadow #(
    parameter int NUM_CH = 24,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [NUM_CH-1:0] clear_in,
    input  logic [NUM_CH-1:0] idle_in,
    input  logic [BYTE_W-1:0] code_in,
    input  logic [NUM_CH-1:0] sig_in,
    input  logic              sigf_in,
    output logic [NUM_CH-1:0] clear_act,
    output logic [NUM_CH-1:0] idle_act,
    output logic [BYTE_W-1:0] code_act,
    output logic [NUM_CH-1:0] sig_act,
    output logic              sigf_act
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clear_act <= '0;
            idle_act  <= '0;
            code_act  <= '0;
            sig_act   <= '0;
            sigf_act  <= 1'b0;
        end else if (load) begin
            clear_act <= clear_in;
            idle_act  <= idle_in;
            code_act  <= code_in;
            sig_act   <= sig_in;
            sigf_act  <= sigf_in;
        end
    end

    // R7
    cfg_frame_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(clear_act) && $stable(idle_act) && $stable(code_act)
                   && $stable(sig_act) && $stable(sigf_act)));

endmodule

// File: rtl/t1ow_slot_fsm.sv
module t1ow_slot_fsm
    import t1ow_pkg::*;
#(
    parameter int NUM_CH = 24,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            in_fbit,
    output logic            chan_slot,
    output logic [CH_W-1:0] chan_idx
);

    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    slot_state_e     st, st_n;
    logic [CH_W-1:0] ch, ch_n;

    always_comb begin
        st_n = st;
        ch_n = ch;
        if (in_valid) begin
            if (in_fbit) begin
                st_n = SL_CHAN;
                ch_n = '0;
            end else begin
                unique case (st)
                    SL_HUNT: st_n = SL_HUNT;
                    SL_CHAN: begin
                        if (ch == LAST_CH) st_n = SL_GAP;
                        else               ch_n = ch + 1'b1;
                    end
                    SL_GAP:  st_n = SL_GAP;
                    default: st_n = SL_HUNT;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= SL_HUNT;
            ch <= '0;
        end else begin
            st <= st_n;
            ch <= ch_n;
        end
    end

    always_comb begin
        chan_slot = in_valid && !in_fbit && (st == SL_CHAN);
        chan_idx  = ch;
    end

    // R2
    chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SL_CHAN) |-> (ch <= LAST_CH));

    // R2
    chan_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fbit) |=> (st == SL_CHAN && ch == '0));

endmodule

// File: rtl/t1ow_byte_edit.sv
module t1ow_byte_edit #(
    parameter int BYTE_W = 8,
    localparam int ROB_BIT   = 0,
    localparam int STUFF_BIT = BYTE_W - 7
) (
    input  logic [BYTE_W-1:0] data_in,
    input  logic              is_chan,
    input  logic              is_idle,
    input  logic              is_clear,
    input  logic              sigf,
    input  logic              sig_bit,
    input  logic [BYTE_W-1:0] idle_code,
    output logic [BYTE_W-1:0] data_out
);

    logic [BYTE_W-1:0] d;

    always_comb begin
        d = data_in;
        if (is_chan) begin
            if (is_idle) begin
                d = idle_code;
            end else if (!is_clear) begin
                if (sigf) d[ROB_BIT] = sig_bit;
                if (d == '0) d[STUFF_BIT] = 1'b1;
            end
        end
        data_out = d;
    end

endmodule

// File: rtl/t1_tx_overwrite.sv
module t1_tx_overwrite #(
    parameter int NUM_CH = 24,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_fbit,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              sig_frame,
    input  logic [NUM_CH-1:0] sig_bits,
    input  logic [NUM_CH-1:0] clear_mask,
    input  logic [NUM_CH-1:0] idle_mask,
    input  logic [BYTE_W-1:0] idle_code,
    output logic              out_valid,
    output logic              out_fbit,
    output logic [BYTE_W-1:0] out_data
);

    localparam int CH_W = $clog2(NUM_CH);

    logic [NUM_CH-1:0] clear_act, idle_act, sig_act;
    logic [BYTE_W-1:0] code_act;
    logic              sigf_act;
    logic              chan_slot;
    logic [CH_W-1:0]   chan_idx;
    logic [NUM_CH-1:0] chan_sel;
    logic              sel_clear, sel_idle, sel_sig;
    logic [BYTE_W-1:0] edited;

    t1ow_cfg_shadow #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (in_valid && in_fbit),
        .clear_in  (clear_mask),
        .idle_in   (idle_mask),
        .code_in   (idle_code),
        .sig_in    (sig_bits),
        .sigf_in   (sig_frame),
        .clear_act (clear_act),
        .idle_act  (idle_act),
        .code_act  (code_act),
        .sig_act   (sig_act),
        .sigf_act  (sigf_act)
    );

    t1ow_slot_fsm #(.NUM_CH(NUM_CH)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_fbit   (in_fbit),
        .chan_slot (chan_slot),
        .chan_idx  (chan_idx)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_sel
        assign chan_sel[k] = (chan_idx == CH_W'(k));
    end

    assign sel_clear = |(clear_act & chan_sel);
    assign sel_idle  = |(idle_act  & chan_sel);
    assign sel_sig   = |(sig_act   & chan_sel);

    t1ow_byte_edit #(.BYTE_W(BYTE_W)) u_edit (
        .data_in   (in_data),
        .is_chan   (chan_slot),
        .is_idle   (sel_idle),
        .is_clear  (sel_clear),
        .sigf      (sigf_act),
        .sig_bit   (sel_sig),
        .idle_code (code_act),
        .data_out  (edited)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_fbit  <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_fbit <= in_fbit;
                out_data <= edited;
            end
        end
    end

    // R1
    fbit_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fbit) |=> (out_fbit && out_data == $past(in_data)));

    // R3
    idle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_slot && sel_idle) |=> (out_data == $past(code_act)));

    // R4
    rob_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_slot && !sel_idle && !sel_clear && sigf_act)
            |=> (out_data[0] == $past(sel_sig)));

    // R5
    no_zero_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_slot && !sel_idle && !sel_clear) |=> (out_data != '0));

    // R6
    clear_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_slot && sel_clear && !sel_idle) |=> (out_data == $past(in_data)));

    // R8
    unaligned_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_fbit && !chan_slot) |=> (out_data == $past(in_data)));

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid)));

endmodule

// File: tb/t1_tx_overwrite_bench.sv
module t1_tx_overwrite_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_fbit = 1'b0;
    logic [7:0]  in_data = '0;
    logic        sig_frame = 1'b0;
    logic [23:0] sig_bits = '0;
    logic [23:0] clear_mask = '0;
    logic [23:0] idle_mask = '0;
    logic [7:0]  idle_code = '0;
    logic        out_valid;
    logic        out_fbit;
    logic [7:0]  out_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    t1_tx_overwrite u_t1_tx_overwrite (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_fbit    (in_fbit),
        .in_data    (in_data),
        .sig_frame  (sig_frame),
        .sig_bits   (sig_bits),
        .clear_mask (clear_mask),
        .idle_mask  (idle_mask),
        .idle_code  (idle_code),
        .out_valid  (out_valid),
        .out_fbit   (out_fbit),
        .out_data   (out_data)
    );

    // {fbit, data in, expected out, requirement number}
    // config: clear ch1,ch2,ch5; idle ch3,ch5; code 7F; sig bit k=1 for even channel k; signaling frame
    localparam logic [20:0] FRAME_TBL [25] = '{
        {1'b1, 8'h01, 8'h01, 4'd1},  // R1 framing slot
        {1'b0, 8'h00, 8'h00, 4'd6},  // R6 ch1 clear zero
        {1'b0, 8'h5A, 8'h5A, 4'd6},  // R6 ch2 clear, sig 1
        {1'b0, 8'h12, 8'h7F, 4'd3},  // R3 ch3 idle
        {1'b0, 8'h00, 8'h01, 4'd4},  // R4 ch4 robbed 1
        {1'b0, 8'h33, 8'h7F, 4'd3},  // R3 ch5 idle beats clear
        {1'b0, 8'hF0, 8'hF1, 4'd4},  // R4 ch6
        {1'b0, 8'h01, 8'h02, 4'd5},  // R5 ch7 robbed to zero then stuffed
        {1'b0, 8'hFF, 8'hFF, 4'd4},  // R4 ch8
        {1'b0, 8'hFF, 8'hFE, 4'd4},  // R4 ch9 robbed 0
        {1'b0, 8'h80, 8'h81, 4'd4},  // R4 ch10
        {1'b0, 8'h00, 8'h02, 4'd5},  // R5 ch11
        {1'b0, 8'h10, 8'h11, 4'd2},  // R2 ch12
        {1'b0, 8'h10, 8'h10, 4'd2},  // R2 ch13
        {1'b0, 8'h10, 8'h11, 4'd2},  // R2 ch14
        {1'b0, 8'h10, 8'h10, 4'd2},  // R2 ch15
        {1'b0, 8'h10, 8'h11, 4'd2},  // R2 ch16
        {1'b0, 8'h10, 8'h10, 4'd2},  // R2 ch17
        {1'b0, 8'h10, 8'h11, 4'd2},  // R2 ch18
        {1'b0, 8'h10, 8'h10, 4'd2},  // R2 ch19
        {1'b0, 8'h10, 8'h11, 4'd2},  // R2 ch20
        {1'b0, 8'h10, 8'h10, 4'd2},  // R2 ch21
        {1'b0, 8'h10, 8'h11, 4'd2},  // R2 ch22
        {1'b0, 8'h10, 8'h10, 4'd2},  // R2 ch23
        {1'b0, 8'h10, 8'h11, 4'd2}   // R2 ch24
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic send(input logic f, input logic [7:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_fbit  = f;
        in_data  = d;
        @(posedge clk);
        #1;
    endtask

    task automatic pause_slot();
        @(negedge clk);
        in_valid = 1'b0;
        in_fbit  = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic load_table_cfg(input logic sf);
        clear_mask = 24'h000013;
        idle_mask  = 24'h000014;
        idle_code  = 8'h7F;
        sig_bits   = 24'hAAAAAA;
        sig_frame  = sf;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10
        chk("R10 out_valid", {7'd0, out_valid}, 8'h00);
        chk("R10 out_fbit", {7'd0, out_fbit}, 8'h00);
        chk("R10 out_data", out_data, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R8 before any framing slot: zero byte not stuffed
        load_table_cfg(1'b1);
        send(1'b0, 8'h00);
        chk("R8 hunt passthrough", out_data, 8'h00);
        chk("R9 valid high", {7'd0, out_valid}, 8'h01);

        // table: one signaling frame
        for (int i = 0; i < 25; i++) begin
            send(FRAME_TBL[i][20], FRAME_TBL[i][19:12]);
            checks++;
            if (out_data !== FRAME_TBL[i][11:4] || out_fbit !== FRAME_TBL[i][20]) begin
                failures++;
                $display("FAIL table slot %0d R%0d actual=%02h/%0b expected=%02h/%0b",
                         i, FRAME_TBL[i][3:0], out_data, out_fbit,
                         FRAME_TBL[i][11:4], FRAME_TBL[i][20]);
            end
        end

        // R8 gap after channel 24
        send(1'b0, 8'h00);
        chk("R8 gap passthrough", out_data, 8'h00);

        // R9 idle cycle
        pause_slot();
        chk("R9 valid low", {7'd0, out_valid}, 8'h00);

        // non-signaling frame
        load_table_cfg(1'b0);
        send(1'b1, 8'h00);
        chk("R1 fbit flag", {7'd0, out_fbit}, 8'h01);
        for (int ch = 1; ch <= 24; ch++) begin
            logic [7:0] d;
            d = (ch == 4) ? 8'h00 : (ch == 6) ? 8'hF0 : 8'h10;
            send(1'b0, d);
            if (ch == 1) chk("R6 clear ch1", out_data, 8'h10);
            if (ch == 3) chk("R3 idle ch3", out_data, 8'h7F);
            if (ch == 4) chk("R5 stuff ch4", out_data, 8'h02);
            if (ch == 6) chk("R4 no rob ch6", out_data, 8'hF0);
        end

        // R7 mid-frame change has no effect until next frame
        load_table_cfg(1'b0);
        send(1'b1, 8'h80);
        send(1'b0, 8'h00);
        chk("R7 ch1 before change", out_data, 8'h00);
        clear_mask = 24'h000000;
        idle_mask  = 24'hFFFFFF;
        idle_code  = 8'hAA;
        sig_frame  = 1'b1;
        send(1'b0, 8'h00);
        chk("R7 ch2 keeps clear", out_data, 8'h00);
        send(1'b0, 8'h00);
        chk("R7 ch3 keeps old code", out_data, 8'h7F);
        send(1'b0, 8'h00);
        chk("R7 ch4 keeps old flag", out_data, 8'h02);
        for (int ch = 5; ch <= 24; ch++) send(1'b0, 8'h10);
        send(1'b1, 8'h00);
        send(1'b0, 8'h00);
        chk("R7 new frame uses new code", out_data, 8'hAA);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule